// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the digital serial front end of an eight-channel successive-approximation converter that runs with the serial clock pacing the conversion. A host drives chip select, serial clock and serial data in. While chip select is low, the block discards leading zero bits until it sees the first one. That bit opens an 8-bit command byte, and the block decodes the channel, the polarity, the input configuration and the clock or power mode from it.

When the command selects serial-clock-paced conversion, the block raises a strobe for one serial clock period. It then shifts a 12-bit result out, most significant bit first, on the following falling edges. The result comes from a parallel sample input that stands in for the analog core. Bipolar results are converted to two's complement on the way out. A one-cycle request output carries the decoded channel pair and mode to the analog core. The two power-down codes are held as flags.

The serial pins are synchronised into a single system clock domain. Serial clock edges are detected there, so all state is clocked by `clk_i`. The two serial outputs come with output enables that stand in for high impedance while chip select is high.

Top module: `adc_sif`

## Requirements
- R1: Serial data is taken only on rising serial clock edges while chip select is low. The data and strobe outputs change only after falling serial clock edges, and stay constant while the serial clock is high.
- R2: Zero bits received after chip select falls are ignored, in any number, and a frame of only zeros raises no request. The first one bit is the start bit, the MSB of the command byte.
- R3: The command byte, MSB first, is start, a three-bit select field s2 s1 s0, unipolar (1) or bipolar (0), single-ended (1) or differential (0), and a two-bit mode field m1 m0. `req_o` pulses for exactly one system clock cycle when the eighth bit is received.
- R4: With the request, `req_pos_o` = {s1,s0,s2} and `req_neg_o` = `req_pos_o` with bit 0 inverted. `req_single_o` is set for single-ended inputs, and in that case `req_neg_o` is unused.
- R5: Mode field 11 selects serial-clock-paced conversion. The strobe goes high at the falling edge that ends the eighth command bit and stays high for exactly one serial clock period. DOUT is low while the strobe is high.
- R6: In mode 11, the 12 result bits appear on DOUT MSB first, one on each of the 12 falling edges that follow the strobe period.
- R7: While chip select is high, both output enables are low and the command decoder returns to hunting. Once chip select is low, the strobe is driven low until a strobe pulse is due.
- R8: A unipolar result is `sample_i` unchanged. A bipolar result is `sample_i` with its MSB inverted, which turns the offset code into two's complement.
- R9: After the last result bit, DOUT is held low until chip select rises.
- R10: Mode 00 sets `pd_full_o`, mode 01 sets `pd_fast_o`, and modes 10 and 11 clear both. The flags hold until the next command byte. Modes other than 11 produce no strobe and keep DOUT low.
- R11: The result is the value of `sample_i` at the completion of the command byte. Later changes to `sample_i` do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data in |
| sample_i | input | RES_W | Parallel converter code (offset binary) |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output enable for dout_o |
| strb_o | output | 1 | Conversion strobe |
| strb_oe_o | output | 1 | Output enable for strb_o |
| req_o | output | 1 | One-cycle sample request |
| req_pos_o | output | 3 | Positive input channel |
| req_neg_o | output | 3 | Negative input channel (differential) |
| req_single_o | output | 1 | Single-ended configuration |
| req_unipolar_o | output | 1 | Unipolar conversion |
| pd_full_o | output | 1 | Full power-down requested |
| pd_fast_o | output | 1 | Fast power-down requested |

## Verification
A decoder stuck in hunting or miscounting the command bits shows up at once: the request pulse is missing or early, and the channel fields are wrong in the same cycle as the request. A wrong output phase or bit counter moves the strobe or the result window by a whole serial clock, so every DOUT sample from the ninth bit on disagrees with the expected stream. Abort and mode handling become visible in the frame that follows. A stale decoder state, or leftover shift data, then corrupts the next request or the next result.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    PD_FULL = 2'b00,
    PD_FAST = 2'b01,
    CLK_INT = 2'b10,
    CLK_EXT = 2'b11
  } pd_mode_e;

  typedef struct packed {
    logic [2:0] sel;
    logic       unipolar;
    logic       single;
    pd_mode_e   pd;
  } ctrl_t;
endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g > 0) ? g-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_sif_ctrl.sv
module adc_sif_ctrl
  import adc_sif_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_act_i,
  input  logic  rise_i,
  input  logic  din_i,
  output logic  done_o,
  output ctrl_t ctrl_o
);
  localparam int BODY  = CTRL_W - 1;
  localparam int CNT_W = $clog2(BODY);

  typedef enum logic [1:0] {S_HUNT, S_BODY, S_HOLD} st_e;

  st_e               st_q;
  logic [BODY-2:0]   sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  ctrl_t             ctrl_q;
  logic [BODY-1:0]   full;

  assign full = {sr_q, din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_HUNT;
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!cs_act_i) begin
        st_q  <= S_HUNT;
        cnt_q <= '0;
      end else if (rise_i) begin
        unique case (st_q)
          S_HUNT: if (din_i) begin
            st_q  <= S_BODY;
            cnt_q <= '0;
          end
          S_BODY: begin
            sr_q <= full[BODY-2:0];
            if (cnt_q == CNT_W'(BODY-1)) begin
              st_q            <= S_HOLD;
              done_q          <= 1'b1;
              ctrl_q.sel      <= full[6:4];
              ctrl_q.unipolar <= full[3];
              ctrl_q.single   <= full[2];
              ctrl_q.pd       <= pd_mode_e'(full[1:0]);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign ctrl_o = ctrl_q;

  a_r2_zero_keeps_hunting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_HUNT && cs_act_i && rise_i && !din_i) |=> st_q == S_HUNT);

  a_r3_done_ends_body: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(st_q) == S_BODY && st_q == S_HOLD));
endmodule

// File: rtl/adc_sif_out.sv
module adc_sif_out
  import adc_sif_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             fall_i,
  input  logic             done_i,
  input  ctrl_t            ctrl_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             dout_o,
  output logic             strb_o
);
  localparam int BC_W = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] SIGN = {1'b1, {(RES_W-1){1'b0}}};

  typedef enum logic [2:0] {O_IDLE, O_WAIT, O_STRB, O_DATA, O_TAIL} ost_e;

  ost_e             st_q;
  logic [RES_W-1:0] sr_q;
  logic [BC_W-1:0]  bc_q;
  logic             dout_q, strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= O_IDLE;
      sr_q   <= '0;
      bc_q   <= '0;
      dout_q <= 1'b0;
      strb_q <= 1'b0;
    end else if (!cs_act_i) begin
      st_q   <= O_IDLE;
      bc_q   <= '0;
      dout_q <= 1'b0;
      strb_q <= 1'b0;
    end else if (done_i) begin
      if (ctrl_i.pd == CLK_EXT) begin
        st_q <= O_WAIT;
        sr_q <= ctrl_i.unipolar ? sample_i : (sample_i ^ SIGN);
      end
    end else if (fall_i) begin
      unique case (st_q)
        O_WAIT: begin
          strb_q <= 1'b1;
          st_q   <= O_STRB;
        end
        O_STRB: begin
          strb_q <= 1'b0;
          dout_q <= sr_q[RES_W-1];
          sr_q   <= sr_q << 1;
          bc_q   <= BC_W'(1);
          st_q   <= O_DATA;
        end
        O_DATA: begin
          if (bc_q == BC_W'(RES_W)) begin
            dout_q <= 1'b0;
            st_q   <= O_TAIL;
          end else begin
            dout_q <= sr_q[RES_W-1];
            sr_q   <= sr_q << 1;
            bc_q   <= bc_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dout_o = dout_q;
  assign strb_o = strb_q;

  a_r5_strb_one_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_q && fall_i && cs_act_i && !done_i) |=> !strb_q);

  a_r5_dout_low_with_strb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_q |-> !dout_q);

  a_r1_dout_only_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_i && !fall_i) |=> ($stable(dout_q) || !cs_act_i));

  a_r9_tail_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == O_TAIL) |-> !dout_q);
endmodule

// File: rtl/adc_sif.sv
module adc_sif
  import adc_sif_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             din_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             strb_o,
  output logic             strb_oe_o,
  output logic             req_o,
  output logic [2:0]       req_pos_o,
  output logic [2:0]       req_neg_o,
  output logic             req_single_o,
  output logic             req_unipolar_o,
  output logic             pd_full_o,
  output logic             pd_fast_o
);
  logic [2:0] pins_s;
  logic       sclk_s, cs_n_s, din_s, sclk_d;
  logic       cs_act, rise, fall, done;
  ctrl_t      ctrl;
  logic       pd_full_q, pd_fast_q;

  adc_sif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({din_i, cs_ni, sclk_i}),
    .q_o    (pins_s)
  );

  assign {din_s, cs_n_s, sclk_s} = pins_s;
  assign cs_act = !cs_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign rise = cs_act &&  sclk_s && !sclk_d;
  assign fall = cs_act && !sclk_s &&  sclk_d;

  adc_sif_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .rise_i   (rise),
    .din_i    (din_s),
    .done_o   (done),
    .ctrl_o   (ctrl)
  );

  adc_sif_out #(.RES_W(RES_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .fall_i   (fall),
    .done_i   (done),
    .ctrl_i   (ctrl),
    .sample_i (sample_i),
    .dout_o   (dout_o),
    .strb_o   (strb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_full_q <= 1'b0;
      pd_fast_q <= 1'b0;
    end else if (done) begin
      pd_full_q <= (ctrl.pd == PD_FULL);
      pd_fast_q <= (ctrl.pd == PD_FAST);
    end
  end

  // select field order is {s2,s1,s0}; channel index is {s1,s0,s2}
  assign req_o          = done;
  assign req_pos_o      = {ctrl.sel[1], ctrl.sel[0], ctrl.sel[2]};
  assign req_neg_o      = {ctrl.sel[1], ctrl.sel[0], !ctrl.sel[2]};
  assign req_single_o   = ctrl.single;
  assign req_unipolar_o = ctrl.unipolar;
  assign pd_full_o      = pd_full_q;
  assign pd_fast_o      = pd_fast_q;
  assign dout_oe_o      = cs_act;
  assign strb_oe_o      = cs_act;

  a_r3_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  a_r10_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |=> $stable({pd_full_q, pd_fast_q}));

  a_r7_strb_low_after_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_act) |-> !strb_o);
endmodule

// File: tb/adc_sif_bench.sv
module adc_sif_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [11:0] sample = '0;
  logic        dout, dout_oe, strb, strb_oe, req, req_single, req_uni, pd_full, pd_fast;
  logic [2:0]  req_pos, req_neg;

  adc_sif u_adc_sif (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .sample_i(sample), .dout_o(dout), .dout_oe_o(dout_oe), .strb_o(strb),
    .strb_oe_o(strb_oe), .req_o(req), .req_pos_o(req_pos), .req_neg_o(req_neg),
    .req_single_o(req_single), .req_unipolar_o(req_uni),
    .pd_full_o(pd_full), .pd_fast_o(pd_fast)
  );

  int checks = 0, errors = 0, req_cnt = 0, hi_chg = 0;
  logic [2:0] r_pos, r_neg;
  logic r_single, r_uni;
  logic [23:0] got_d, got_s;

  always @(negedge clk) if (req) begin
    req_cnt++;
    r_pos = req_pos; r_neg = req_neg; r_single = req_single; r_uni = req_uni;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(logic b, output logic d, output logic s);
    logic d0, s0;
    din = b;
    repeat (HALF) @(negedge clk);
    d0 = dout; s0 = strb; d = dout; s = strb;
    sclk = 1'b1;
    repeat (HALF/2) @(negedge clk);
    din = ~din;
    repeat (HALF - HALF/2) @(negedge clk);
    if (dout !== d0 || strb !== s0) hi_chg++;
    sclk = 1'b0;
  endtask

  task automatic select_low();
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic select_high();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(int lead, logic [7:0] ctl, logic [11:0] s0);
    logic d, s;
    sample = s0;
    select_low();
    for (int i = 0; i < lead + 24; i++) begin
      bit_cycle((i < lead) ? 1'b0 : (i < lead + 8) ? ctl[7-(i-lead)] : 1'b0, d, s);
      if (i >= lead) begin
        got_d[i-lead] = d;
        got_s[i-lead] = s;
      end
      if (i == lead + 7) sample = ~s0;  // R11: change after capture
    end
    select_high();
  endtask

  task automatic check_frame(string tag, logic [7:0] ctl, logic [11:0] code);
    logic [23:0] ed, es;
    ed = '0; es = '0;
    if (ctl[1:0] == 2'b11) begin
      es[8] = 1'b1;
      for (int b = 0; b < 12; b++) ed[9+b] = code[11-b];
    end
    check({tag, " R5 strobe"}, got_s, es);
    check({tag, " R6 R9 R11 dout stream"}, got_d, ed);
    check({tag, " R1 outputs steady while sclk high"}, hi_chg, 0);
    check({tag, " R7 oe low after deselect"}, {dout_oe, strb_oe}, 2'b00);
  endtask

  task automatic t_reset();
    check("R7 reset oe", {dout_oe, strb_oe}, 2'b00);
    check("R3 reset req", req, 1'b0);
    check("R10 reset pd", {pd_full, pd_fast}, 2'b00);
  endtask

  task automatic t_select();
    select_low();
    check("R7 oe on select", {dout_oe, strb_oe}, 2'b11);
    check("R7 strobe low on select", strb, 1'b0);
    select_high();
  endtask

  task automatic t_ext_unipolar();
    int n0;
    n0 = req_cnt; hi_chg = 0;
    frame(3, 8'b1_101_1_1_11, 12'hA5C);
    check("R2 R3 one request after leading zeros", req_cnt - n0, 1);
    check("R4 pos channel", r_pos, 3'd3);
    check("R4 single flag", r_single, 1'b1);
    check("R8 unipolar flag", r_uni, 1'b1);
    check_frame("ext uni", 8'b1_101_1_1_11, 12'hA5C);
  endtask

  task automatic t_ext_bipolar();
    hi_chg = 0;
    frame(0, 8'b1_100_0_0_11, 12'h3F0);
    check("R4 diff pos", r_pos, 3'd1);
    check("R4 diff neg", r_neg, 3'd0);
    check("R4 diff flag", r_single, 1'b0);
    check_frame("R8 bipolar", 8'b1_100_0_0_11, 12'hBF0);
    hi_chg = 0;
    frame(5, 8'b1_011_0_0_11, 12'h800);
    check("R4 diff pair 3 pos", r_pos, 3'd6);
    check("R4 diff pair 3 neg", r_neg, 3'd7);
    check_frame("R8 bipolar midscale", 8'b1_011_0_0_11, 12'h000);
  endtask

  task automatic t_modes();
    hi_chg = 0;
    frame(1, 8'b1_000_1_1_00, 12'hFFF);
    check("R10 full power-down flags", {pd_full, pd_fast}, 2'b10);
    check_frame("R10 mode 00", 8'b1_000_1_1_00, 12'h000);
    hi_chg = 0;
    frame(1, 8'b1_000_1_1_01, 12'hFFF);
    check("R10 fast power-down flags", {pd_full, pd_fast}, 2'b01);
    check_frame("R10 mode 01", 8'b1_000_1_1_01, 12'h000);
    hi_chg = 0;
    frame(2, 8'b1_111_1_1_10, 12'hFFF);
    check("R10 internal mode flags", {pd_full, pd_fast}, 2'b00);
    check("R4 ch7 pos", r_pos, 3'd7);
    check_frame("R10 mode 10", 8'b1_111_1_1_10, 12'h000);
  endtask

  task automatic t_abort();
    logic d, s;
    int n0;
    n0 = req_cnt;
    select_low();
    bit_cycle(1'b1, d, s); bit_cycle(1'b0, d, s);
    bit_cycle(1'b1, d, s); bit_cycle(1'b0, d, s);
    select_high();
    check("R7 abort no request", req_cnt - n0, 0);
    check("R7 abort oe low", {dout_oe, strb_oe}, 2'b00);
    hi_chg = 0;
    frame(0, 8'b1_010_1_1_11, 12'h123);
    check("R7 hunt restarts after abort", r_pos, 3'd4);
    check_frame("R7 after abort", 8'b1_010_1_1_11, 12'h123);
  endtask

  task automatic t_zeros();
    logic d, s;
    int n0;
    logic any_d;
    n0 = req_cnt; any_d = 1'b0;
    select_low();
    for (int i = 0; i < 16; i++) begin
      bit_cycle(1'b0, d, s);
      any_d = any_d | d | s;
    end
    select_high();
    check("R2 zeros raise no request", req_cnt - n0, 0);
    check("R2 zeros keep outputs low", any_d, 1'b0);
  endtask

  logic done_flag = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_select();
    t_ext_unipolar();
    t_ext_bipolar();
    t_modes();
    t_abort();
    t_zeros();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule